// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a station-management engine that performs one MDIO read or write transaction at a time towards an external PHY. A host sees four word registers: control, command, data and status. For a write it first loads the 16-bit data register and then writes the command register. For a read it writes the command register, waits until the busy flag in the status register drops, and then reads the result from the data register.

The engine generates MDC by dividing the bus clock by a programmable divisor. It shifts the serial management frame out on MDIO, releases the line during read turnaround and read data, and samples the PHY's reply on each rising MDC edge. The control register holds the divisor (written as divisor minus one), a preamble-suppress enable that shortens every frame from 64 to 32 bit periods, and a soft reset bit that clears itself.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After `rst_ni` is asserted:
  - the status register reads 0 and the data register reads 0;
  - the control register reads 0x4E00 (divisor field 39 in bits 15:9, suppress bit 8 and reset bit 0 both clear);
  - `mdc_o` and `mdio_oe_o` are low.
- R2: A write to the command register (address 1) starts a transaction when the engine is idle.
  - Bit 15 selects a read and bit 14 selects a write. When both are set, the transaction is a read.
  - Bits 9:5 hold the PHY address and bits 4:0 hold the register number.
  - A command word with neither bit 15 nor bit 14 set starts nothing.
- R3: Status bit 0 (address 3) reads 1 from the cycle after a command is accepted, for exactly N*D cycles, then reads 0.
  - N is 64, or 32 when preamble suppression is on.
  - D is the divisor field plus one; a field of 0 is treated as 1, giving D = 2.
- R4: While busy, each MDC period lasts D bus cycles: MDC is low for floor(D/2) cycles and then high for the remaining cycles. MDC is low whenever the engine is idle.
- R5: A write frame is driven with `mdio_oe_o` high for every bit period, one bit per MDC period, MSB first, in this order:
  - 32 ones;
  - start bits 01;
  - opcode 01;
  - the 5-bit PHY address;
  - the 5-bit register number;
  - turnaround 10;
  - the 16 data-register bits.
- R6: A read frame uses opcode 10 and drives `mdio_oe_o` low for its last 18 bit periods.
  - `mdio_i` is sampled at the rising MDC edge of each of the last 16 periods, first sample into the MSB.
  - The captured word is in the data register (address 2) when busy clears.
- R7: Control bit 8 set drops the 32 preamble ones; every other field of the frame is unchanged.
- R8: While busy, writes to the command register and to the data register are ignored. The running frame, its length and the data register are unaffected.
- R9: After a read, the data register keeps the captured word until the host writes it, a later read completes, or a soft reset occurs. A following write command transmits that word.
- R10: Writing control bit 0 as 1 has the following effects:
  - any transfer is aborted, so busy reads 0 from the next cycle;
  - the data register is cleared;
  - control bit 0 reads 1 for RST_CYCLES (default 4) cycles and then reads 0;
  - commands written while control bit 0 reads 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index: 0 control, 1 command, 2 data, 3 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the register selected by reg_addr_i (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe_o | output | 1 | Output enable for MDIO; low releases the line |
| mdio_i | input | 1 | Serial data in from the PHY |

## Verification
The checker watches several properties on every cycle:
- MDC and the output enable stay low while the engine is idle;
- an accepted command raises busy;
- a soft reset drops busy on the next cycle;
- the data register holds still during a transfer and while idle, unless the host writes it.

Only the bench's scenarios can show the rest. Those are the bit-exact frame content, which the scoreboard compares at each MDC rise, the high-phase length, the exact busy length for both frame sizes and both divisors, the capture of a modelled PHY reply, command-bit priority, the ignoring of accesses during a transfer, and the length of the soft reset window.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CMD  = 2'd1,
    REG_DATA = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  localparam int CMD_RD_BIT   = 15;
  localparam int CMD_WR_BIT   = 14;
  localparam int CTRL_DIV_LSB = 9;
  localparam int CTRL_PRE_BIT = 8;
  localparam int CTRL_RST_BIT = 0;

  localparam int DATA_W    = 16;
  localparam int PRE_BITS  = 32;
  localparam int FRAME_W   = 64;
  localparam int IDX_W     = $clog2(FRAME_W);
  localparam int RELEASE_N = DATA_W + 2;

  typedef struct packed {
    logic              rd;
    logic [4:0]        phy;
    logic [4:0]        regn;
    logic [DATA_W-1:0] wdata;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_m1_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             last_o
);
  logic [DIV_W-1:0] cnt_q, limit, half;
  logic [DIV_W:0]   lim_p1;

  assign limit  = (div_m1_i == '0) ? DIV_W'(1) : div_m1_i;
  assign lim_p1 = {1'b0, limit} + 1'b1;
  assign half   = lim_p1[DIV_W:1];

  assign mdc_o  = run_i && (cnt_q >= half);
  assign rise_o = run_i && (cnt_q == half - 1'b1);
  assign last_o = run_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!run_i || cnt_q == limit) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  mdio_cmd_t         cmd_i,
  input  logic              presup_i,
  input  logic              rise_i,
  input  logic              last_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] cap_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  logic [FRAME_W-1:0] frame_q;
  logic [IDX_W-1:0]   idx_q;
  logic               busy_q, rd_q;
  logic [DATA_W-1:0]  cap_q;
  logic               released;

  assign released  = rd_q && (idx_q < IDX_W'(RELEASE_N));
  assign busy_o    = busy_q;
  assign done_o    = busy_q && last_i && (idx_q == '0);
  assign cap_o     = cap_q;
  assign mdio_oe_o = busy_q && !released;
  assign mdio_o    = mdio_oe_o && frame_q[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      rd_q    <= cmd_i.rd;
      idx_q   <= presup_i ? IDX_W'(FRAME_W - PRE_BITS - 1) : IDX_W'(FRAME_W - 1);
      frame_q <= {{PRE_BITS{1'b1}}, 2'b01,
                  cmd_i.rd ? 2'b10 : 2'b01,
                  cmd_i.phy, cmd_i.regn,
                  cmd_i.rd ? 2'b00 : 2'b10,
                  cmd_i.rd ? {DATA_W{1'b0}} : cmd_i.wdata};
    end else if (busy_q && last_i) begin
      if (idx_q == '0) busy_q <= 1'b0;
      else             idx_q  <= idx_q - 1'b1;
    end
  end

  // capture on MDC rise, only while the data field of a read is on the wire
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cap_q <= '0;
    else if (start_i)               cap_q <= '0;
    else if (busy_q && rise_i && rd_q && idx_q < IDX_W'(DATA_W))
      cap_q <= {cap_q[DATA_W-2:0], mdio_i};
  end
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W      = 7,
  parameter int DIV_RST    = 39,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] cap_i,
  output logic              start_o,
  output logic              abort_o,
  output mdio_cmd_t         cmd_o,
  output logic [DIV_W-1:0]  div_m1_o,
  output logic              presup_o
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  reg_sel_e          sel;
  logic [DIV_W-1:0]  div_q;
  logic              pre_q, pend_rd_q, soft_wr;
  logic [RC_W-1:0]   rst_cnt_q;
  logic [DATA_W-1:0] data_q;

  assign sel      = reg_sel_e'(addr_i);
  assign soft_wr  = we_i && sel == REG_CTRL && wdata_i[CTRL_RST_BIT];
  assign abort_o  = soft_wr || (rst_cnt_q != '0);
  assign start_o  = we_i && sel == REG_CMD && !busy_i && !abort_o &&
                    (wdata_i[CMD_RD_BIT] || wdata_i[CMD_WR_BIT]);
  assign cmd_o    = '{rd: wdata_i[CMD_RD_BIT], phy: wdata_i[9:5],
                      regn: wdata_i[4:0], wdata: data_q};
  assign div_m1_o = div_q;
  assign presup_o = pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= DIV_W'(DIV_RST);
      pre_q     <= 1'b0;
      rst_cnt_q <= '0;
      data_q    <= '0;
      pend_rd_q <= 1'b0;
    end else begin
      if (we_i && sel == REG_CTRL) begin
        div_q <= wdata_i[CTRL_DIV_LSB +: DIV_W];
        pre_q <= wdata_i[CTRL_PRE_BIT];
      end
      if (soft_wr)                rst_cnt_q <= RC_W'(RST_CYCLES);
      else if (rst_cnt_q != '0)   rst_cnt_q <= rst_cnt_q - 1'b1;
      if (abort_o)                data_q <= '0;
      else if (done_i && pend_rd_q) data_q <= cap_i;
      else if (we_i && sel == REG_DATA && !busy_i) data_q <= wdata_i[DATA_W-1:0];
      if (start_o) pend_rd_q <= wdata_i[CMD_RD_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      REG_CTRL: begin
        rdata_o[CTRL_DIV_LSB +: DIV_W] = div_q;
        rdata_o[CTRL_PRE_BIT]          = pre_q;
        rdata_o[CTRL_RST_BIT]          = rst_cnt_q != '0;
      end
      REG_DATA: rdata_o[DATA_W-1:0] = data_q;
      REG_STAT: rdata_o[0]          = busy_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W      = 7,
  parameter int DIV_RST    = 39,
  parameter int RST_CYCLES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic              busy_w, done_w, start_w, abort_w, presup_w, rise_w, last_w;
  logic [DIV_W-1:0]  div_w;
  logic [DATA_W-1:0] cap_w;
  mdio_cmd_t         cmd_w;

  mdio_host_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST), .RST_CYCLES(RST_CYCLES)) i_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .busy_i(busy_w), .done_i(done_w), .cap_i(cap_w),
    .start_o(start_w), .abort_o(abort_w), .cmd_o(cmd_w), .div_m1_o(div_w),
    .presup_o(presup_w)
  );

  mdio_clk_gen #(.DIV_W(DIV_W)) i_clk (
    .clk_i, .rst_ni, .run_i(busy_w), .div_m1_i(div_w),
    .mdc_o, .rise_o(rise_w), .last_o(last_w)
  );

  mdio_frame_shifter i_shift (
    .clk_i, .rst_ni, .start_i(start_w), .abort_i(abort_w), .cmd_i(cmd_w),
    .presup_i(presup_w), .rise_i(rise_w), .last_i(last_w), .mdio_i,
    .busy_o(busy_w), .done_o(done_w), .cap_o(cap_w), .mdio_o, .mdio_oe_o
  );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [1:0]  reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic        busy_i,
  input logic        abort_i,
  input logic        done_i,
  input logic [15:0] data_i,
  input logic        mdc_i,
  input logic        oe_i
);
  p_idle_mdc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdc_i);

  p_idle_oe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !oe_i);

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd1 && reg_wdata_i[15] && !busy_i && !abort_i) |=> busy_i);

  p_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !busy_i);

  p_data_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !done_i && !abort_i) |=> $stable(data_i));

  p_data_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !abort_i && !(reg_we_i && reg_addr_i == 2'd2)) |=> $stable(data_i));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk i_chk (
  .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
  .busy_i(busy_w), .abort_i(abort_w), .done_i(done_w), .data_i(cmd_w.wdata),
  .mdc_i(mdc_o), .oe_i(mdio_oe_o)
);

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  int n_chk = 0, n_bad = 0;
  logic [2:0] exp_q[$];       // {compare bit, bit, oe}
  int   rise_cnt = 0, frame_len = 64;
  logic [15:0] phy_word = '0;
  int   exp_hi = 2, hi_len = 0;
  bit   hi_chk = 1'b0;
  logic prev_mdc = 1'b0;

  always #2.5 clk_i = ~clk_i;

  mdio_mgmt_ctrl i_mdio_mgmt_ctrl (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    reg_addr_i = 2'd3; #1;
    while (reg_rdata_o[0] && cyc < 20000) begin
      cyc++;
      @(negedge clk_i); #1;
    end
  endtask

  // driver: expected bit stream into the scoreboard
  task automatic push_frame(bit rd, bit pre, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
    logic [63:0] f;
    int n;
    f = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, rd ? 2'b00 : 2'b10, rd ? 16'h0 : d};
    n = pre ? 32 : 64;
    frame_len = n; rise_cnt = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (rd && i < 18) exp_q.push_back(3'b000);
      else              exp_q.push_back({1'b1, f[i], 1'b1});
    end
  endtask

  // monitor + PHY model
  always @(negedge clk_i) begin
    if (mdc_o && !prev_mdc) begin
      logic [2:0] e;
      rise_cnt++;
      if (exp_q.size() == 0) check("R5 unexpected MDC rise", 1, 0);
      else begin
        e = exp_q.pop_front();
        check("R5/R6 mdio_oe_o", {31'b0, mdio_oe_o}, {31'b0, e[0]});
        if (e[2]) check("R5/R7 mdio_o bit", {31'b0, mdio_o}, {31'b0, e[1]});
      end
      if (rise_cnt >= frame_len - 16 && rise_cnt < frame_len)
        mdio_i = phy_word[frame_len - 1 - rise_cnt];
      else mdio_i = 1'b1;
    end
    if (mdc_o) hi_len++;
    else if (prev_mdc) begin
      if (hi_chk) check("R4 MDC high phase", hi_len, exp_hi);
      hi_len = 0;
    end
    prev_mdc = mdc_o;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int cyc;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    reg_read(2'd0, r); check("R1 ctrl reset", r, 32'h0000_4E00);
    reg_read(2'd3, r); check("R1 status reset", r, 0);
    reg_read(2'd2, r); check("R1 data reset", r, 0);
    check("R1 mdc/oe idle", {30'b0, mdc_o, mdio_oe_o}, 0);
    rst_ni = 1'b1;
    reg_read(2'd0, r); check("R1 ctrl after release", r, 32'h0000_4E00);

    // R2 R3 R4 R5: write frame, D=4
    reg_write(2'd0, 32'h0000_0600);
    exp_hi = 2; hi_chk = 1;
    reg_write(2'd2, 32'h0000_A5C3);
    push_frame(0, 0, 5'd5, 5'h11, 16'hA5C3);
    reg_write(2'd1, 32'h0000_4000 | (5 << 5) | 32'h11);
    wait_idle(cyc); check("R3 busy length write D4", cyc, 256);
    check("R5 scoreboard drained", exp_q.size(), 0);

    // R6: read frame, D=4
    phy_word = 16'hBEEF;
    push_frame(1, 0, 5'h1F, 5'h02, 16'h0);
    reg_write(2'd1, 32'h0000_8000 | (31 << 5) | 32'h02);
    wait_idle(cyc); check("R3 busy length read D4", cyc, 256);
    reg_read(2'd2, r); check("R6 read capture", r, 32'h0000_BEEF);
    check("R6 scoreboard drained", exp_q.size(), 0);

    // R9: data holds, next write transmits captured word
    repeat (20) @(negedge clk_i);
    reg_read(2'd2, r); check("R9 data held", r, 32'h0000_BEEF);
    push_frame(0, 0, 5'd1, 5'd3, 16'hBEEF);
    reg_write(2'd1, 32'h0000_4000 | (1 << 5) | 32'd3);
    wait_idle(cyc); check("R9 write after read", cyc, 256);
    reg_read(2'd2, r); check("R9 data kept after write cmd", r, 32'h0000_BEEF);

    // R7: preamble suppression read, divisor field 0 -> D=2
    reg_write(2'd0, 32'h0000_0100);
    exp_hi = 1;
    phy_word = 16'h8001;
    push_frame(1, 1, 5'd7, 5'd9, 16'h0);
    reg_write(2'd1, 32'h0000_8000 | (7 << 5) | 32'd9);
    wait_idle(cyc); check("R7 R3 busy length short read", cyc, 64);
    reg_read(2'd2, r); check("R7 short read capture", r, 32'h0000_8001);

    // R7: preamble suppression write
    reg_write(2'd2, 32'h0000_3C5A);
    push_frame(0, 1, 5'd18, 5'd27, 16'h3C5A);
    reg_write(2'd1, 32'h0000_4000 | (18 << 5) | 32'd27);
    wait_idle(cyc); check("R7 busy length short write", cyc, 64);
    check("R7 scoreboard drained", exp_q.size(), 0);

    // R2: both op bits -> read; no op bits -> nothing
    phy_word = 16'h6A95;
    push_frame(1, 1, 5'd2, 5'd4, 16'h0);
    reg_write(2'd1, 32'h0000_C000 | (2 << 5) | 32'd4);
    wait_idle(cyc); check("R2 both bits busy length", cyc, 64);
    reg_read(2'd2, r); check("R2 both bits is read", r, 32'h0000_6A95);
    reg_write(2'd1, 32'h0000_03FF);
    wait_idle(cyc); check("R2 no op bits stays idle", cyc, 0);

    // R8: data and command writes during a transfer are ignored (D=4, full frame)
    reg_write(2'd0, 32'h0000_0600);
    exp_hi = 2;
    reg_write(2'd2, 32'h0000_0F0F);
    push_frame(0, 0, 5'd9, 5'd1, 16'h0F0F);
    reg_write(2'd1, 32'h0000_4000 | (9 << 5) | 32'd1);
    repeat (40) @(negedge clk_i);
    reg_write(2'd2, 32'h0000_FFFF);
    reg_write(2'd1, 32'h0000_8000 | 32'h3FF);
    wait_idle(cyc); check("R8 frame length unchanged", cyc, 256 - 44);
    reg_read(2'd2, r); check("R8 data write ignored", r, 32'h0000_0F0F);
    check("R8 scoreboard drained", exp_q.size(), 0);

    // R10: soft reset aborts a transfer
    push_frame(0, 0, 5'd3, 5'd3, 16'h0F0F);
    reg_write(2'd1, 32'h0000_4000 | (3 << 5) | 32'd3);
    repeat (30) @(negedge clk_i);
    hi_chk = 0;
    reg_write(2'd0, 32'h0000_0601);
    #1; reg_addr_i = 2'd3; #0.5; check("R10 busy drops", reg_rdata_o, 0);
    reg_addr_i = 2'd0; #0.5; check("R10 reset bit set", reg_rdata_o, 32'h0000_0601);
    reg_addr_i = 2'd2; #0.5; check("R10 data cleared", reg_rdata_o, 0);
    exp_q.delete();
    reg_write(2'd1, 32'h0000_4000 | 32'd1);
    reg_read(2'd3, r); check("R10 cmd during reset ignored", r, 0);
    repeat (2) @(negedge clk_i); #1;
    reg_addr_i = 2'd0; #0.5; check("R10 reset bit self-clears", reg_rdata_o, 32'h0000_0600);
    reg_addr_i = 2'd3; #0.5; check("R10 still idle", reg_rdata_o, 0);
    check("R10 no MDC after abort", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule